// File: doc/BRIEF.md
# Byte Rotate and Shift Unit with Condition Flags

This block is the rotate and shift datapath slice of a small 8-bit processor core. It is purely combinational. In one cycle it takes an operand byte, the current carry flag and a 3-bit operation code, and it returns the transformed byte together with a packed flag byte. The operations are circular rotates, rotates through carry, an arithmetic left shift and an arithmetic right shift.

A separate short-form select marks the compact accumulator variants of the four rotates. These variants produce the same byte and the same carry as the general forms. They differ only in that the zero flag is always cleared. The surrounding core owns register and memory access and instruction decode. This unit only computes.

Top module: `bitrot_unit`

## Requirements
- R1: Operation code 0 (circular left) returns the operand shifted left by one with the old bit 7 in bit 0; the carry flag becomes the old bit 7.
- R2: Operation code 1 (circular right) returns the operand shifted right by one with the old bit 0 in bit 7; the carry flag becomes the old bit 0.
- R3: Operation code 2 (left through carry) shifts left, puts the incoming carry into bit 0, and sets the carry flag to the old bit 7.
- R4: Operation code 3 (right through carry) shifts right, puts the incoming carry into bit 7, and sets the carry flag to the old bit 0.
- R5: Operation code 4 (arithmetic left) shifts left with a zero fill in bit 0; the carry flag becomes the old bit 7.
- R6: Operation code 5 (arithmetic right) shifts right and copies the old bit 7 into bit 7; the carry flag becomes the old bit 0.
- R7: The flag byte always has subtract (bit 6) and half-carry (bit 5) cleared, and bits 3..0 read 0; carry sits at bit 4.
- R8: With short-form low, the zero flag (bit 7) is 1 exactly when the 8-bit result is 0.
- R9: With short-form high and a rotate code (0 to 3), the zero flag is 0 whatever the result; result and carry match the general form.
- R10: With a shift code (4 or 5), the short-form select has no effect on the result or any flag.
- R11: Operation codes 6 and 7 are reserved: the result equals the operand, carry equals the incoming carry, and zero follows R8 and R9 as for a non-rotate code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 8 | Byte to transform |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 3 | Operation code (0..5 defined, 6..7 reserved) |
| short_i | input | 1 | Accumulator short-form select (rotates only) |
| result_o | output | 8 | Transformed byte |
| flags_o | output | 8 | Packed flags: zero 7, subtract 6, half-carry 5, carry 4, bits 3..0 zero |

## Verification
Zero detection and short-form masking can apply to the same operation. A rotate whose result is 0, such as a circular rotate of 0x00 or a through-carry rotate of 0x80 or 0x01 with the incoming carry clear, must report zero in the general form and non-zero in the short form. The sweep drives every operand with both carry values, every code and both short-form settings. It judges the zero bit separately from the result and the carry, so a masking error cannot hide behind a correct byte.

// File: rtl/bitrot_pkg.sv
// Package: shared operation codes and flag bit positions for the rotate/shift unit.
// Assumes an 8-bit packed flag byte; data width is set by the modules' parameters.
package bitrot_pkg;

    typedef enum logic [2:0] {
        OP_ROL_CIRC = 3'd0,
        OP_ROR_CIRC = 3'd1,
        OP_ROL_CARRY = 3'd2,
        OP_ROR_CARRY = 3'd3,
        OP_SHL_ARITH = 3'd4,
        OP_SHR_ARITH = 3'd5,
        OP_RSVD_6 = 3'd6,
        OP_RSVD_7 = 3'd7
    } bitrot_op_e;

    localparam int FLAG_W = 8;
    localparam int ZF_POS = 7;
    localparam int NF_POS = 6;
    localparam int HF_POS = 5;
    localparam int CF_POS = 4;

endpackage

// File: rtl/bitrot_rotator.sv
// Module: one-position rotator covering circular and through-carry rotates in
// both directions. Assumes W >= 2. dir_right_i picks direction, thru_i selects
// whether the incoming carry (instead of the wrapped bit) fills the vacated end.
module bitrot_rotator #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic         carry_i,
    input  logic         dir_right_i,
    input  logic         thru_i,
    output logic [W-1:0] data_o,
    output logic         carry_o
);
    logic [W-1:0] left_v;
    logic [W-1:0] right_v;
    logic         fill_left;
    logic         fill_right;

    // Pick the bit that enters the vacated position for each direction.
    always_comb begin
        fill_left  = thru_i ? carry_i : data_i[W-1];
        fill_right = thru_i ? carry_i : data_i[0];
    end

    // Bitwise neighbour wiring for both directions.
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            if (g == 0) begin : g_lo
                assign left_v[g]  = fill_left;
                assign right_v[g] = data_i[g+1];
            end else if (g == W-1) begin : g_hi
                assign left_v[g]  = data_i[g-1];
                assign right_v[g] = fill_right;
            end else begin : g_mid
                assign left_v[g]  = data_i[g-1];
                assign right_v[g] = data_i[g+1];
            end
        end
    endgenerate

    // Select the direction and the bit that leaves toward the carry.
    always_comb begin
        data_o  = dir_right_i ? right_v : left_v;
        carry_o = dir_right_i ? data_i[0] : data_i[W-1];
    end

    // R2
    rot_exit_right_chk: assert final (!(dir_right_i === 1'b1) || $isunknown(data_i) ||
                                      carry_o == data_i[0])
        else $error("rotator right exit bit wrong");

endmodule

// File: rtl/bitrot_shifter.sv
// Module: one-position arithmetic shifter. Left shift fills the low bit with 0,
// right shift replicates the sign bit. The outgoing bit becomes the carry.
// Assumes W >= 2.
module bitrot_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_i,
    input  logic         dir_right_i,
    output logic [W-1:0] data_o,
    output logic         carry_o
);
    logic [W-1:0] shl_v;
    logic [W-1:0] sar_v;

    // Build both shifted forms from the operand.
    always_comb begin
        shl_v = {data_i[W-2:0], 1'b0};
        sar_v = {data_i[W-1], data_i[W-1:1]};
    end

    // Choose direction and the departing bit.
    always_comb begin
        data_o  = dir_right_i ? sar_v : shl_v;
        carry_o = dir_right_i ? data_i[0] : data_i[W-1];
    end

    // R6
    sar_sign_chk: assert final (!(dir_right_i === 1'b1) || $isunknown(data_i) ||
                                data_o[W-1] == data_i[W-1])
        else $error("arithmetic right lost the sign");

endmodule

// File: rtl/bitrot_flagpack.sv
// Module: derives the zero flag and packs the flag byte. Zero is forced low for
// short-form rotates, otherwise it reflects an all-zero result. Subtract,
// half-carry and the low nibble are always 0.
module bitrot_flagpack #(
    parameter int W = 8
) (
    input  logic [W-1:0]                   result_i,
    input  logic                           carry_i,
    input  logic                           mask_zero_i,
    output logic [bitrot_pkg::FLAG_W-1:0]  flags_o
);
    import bitrot_pkg::*;

    logic zero_v;

    // Zero detection with the short-form mask applied.
    always_comb begin
        zero_v = (result_i == '0) && !mask_zero_i;
    end

    // Pack flags into their fixed positions.
    always_comb begin
        flags_o         = '0;
        flags_o[ZF_POS] = zero_v;
        flags_o[NF_POS] = 1'b0;
        flags_o[HF_POS] = 1'b0;
        flags_o[CF_POS] = carry_i;
    end

endmodule

// File: rtl/bitrot_unit.sv
// Module: top of the combinational rotate/shift unit. Decodes the operation
// code, steers the operand through the rotator or shifter, and packs flags.
// Assumes short_i is meaningful only with rotate codes; reserved codes pass
// the operand and the incoming carry straight through.
module bitrot_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] operand_i,
    input  logic         carry_i,
    input  logic [2:0]   op_i,
    input  logic         short_i,
    output logic [W-1:0] result_o,
    output logic [7:0]   flags_o
);
    import bitrot_pkg::*;

    logic         is_rot;
    logic         is_shift;
    logic [W-1:0] rot_data;
    logic         rot_carry;
    logic [W-1:0] sh_data;
    logic         sh_carry;
    logic         out_carry;
    logic         mask_zero;

    // Decode the operation class from the code.
    always_comb begin
        is_rot    = (op_i[2] == 1'b0);
        is_shift  = (op_i[2:1] == 2'b10);
        mask_zero = is_rot && short_i;
    end

    bitrot_rotator #(.W(W)) u_rot (
        .data_i      (operand_i),
        .carry_i     (carry_i),
        .dir_right_i (op_i[0]),
        .thru_i      (op_i[1]),
        .data_o      (rot_data),
        .carry_o     (rot_carry)
    );

    bitrot_shifter #(.W(W)) u_shift (
        .data_i      (operand_i),
        .dir_right_i (op_i[0]),
        .data_o      (sh_data),
        .carry_o     (sh_carry)
    );

    // Steer the selected datapath to the outputs.
    always_comb begin
        if (is_rot) begin
            result_o  = rot_data;
            out_carry = rot_carry;
        end else if (is_shift) begin
            result_o  = sh_data;
            out_carry = sh_carry;
        end else begin
            result_o  = operand_i;
            out_carry = carry_i;
        end
    end

    bitrot_flagpack #(.W(W)) u_flags (
        .result_i    (result_o),
        .carry_i     (out_carry),
        .mask_zero_i (mask_zero),
        .flags_o     (flags_o)
    );

    // R7
    fixed_flags_chk: assert final ($isunknown(op_i) ||
                                   (flags_o[NF_POS] == 1'b0 && flags_o[HF_POS] == 1'b0 &&
                                    flags_o[3:0] == 4'h0))
        else $error("subtract/half-carry/low nibble not clear");

    // R9
    short_zero_chk: assert final ($isunknown(op_i) || $isunknown(short_i) ||
                                  !(op_i[2] == 1'b0 && short_i) || flags_o[ZF_POS] == 1'b0)
        else $error("short-form rotate reported zero");

    // R8
    zero_match_chk: assert final ($isunknown(op_i) || $isunknown(short_i) ||
                                  $isunknown(operand_i) || $isunknown(carry_i) ||
                                  short_i || flags_o[ZF_POS] == (result_o == '0))
        else $error("zero flag does not follow result");

    // R11
    rsvd_pass_chk: assert final ($isunknown(op_i) || $isunknown(operand_i) ||
                                 op_i[2:1] != 2'b11 || result_o == operand_i)
        else $error("reserved code altered the operand");

endmodule

// File: tb/tb_bitrot_unit.sv
// Bench: exhaustive sweep of operand, incoming carry, code and short-form,
// with expected byte and flags computed arithmetically.
module tb_bitrot_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] operand;
    logic       cin;
    logic [2:0] op;
    logic       short_sel;
    logic [7:0] result;
    logic [7:0] flags;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bitrot_unit dut (
        .operand_i (operand),
        .carry_i   (cin),
        .op_i      (op),
        .short_i   (short_sel),
        .result_o  (result),
        .flags_o   (flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s op=%0d short=%0b a=%02h cin=%0b act=%02h exp=%02h",
                     req, op, short_sel, operand, cin, act, exp);
        end
    endtask

    function automatic string op_req(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        operand = 8'h00; cin = 1'b0; op = 3'd0; short_sel = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // idle state: all-zero inputs give result 0 and zero flag only (R8)
        chk("R8", result, 0);
        chk("R8", flags, 8'h80);

        for (int o = 0; o < 8; o++) begin
            for (int s = 0; s < 2; s++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int a = 0; a < 256; a++) begin
                        int er;
                        int ec;
                        int ez;
                        @(posedge clk);
                        operand = a[7:0]; cin = c[0]; op = o[2:0]; short_sel = s[0];
                        case (o)
                            0: begin er = ((a * 2) % 256) + a / 128; ec = a / 128; end
                            1: begin er = a / 2 + (a % 2) * 128; ec = a % 2; end
                            2: begin er = ((a * 2) % 256) + c; ec = a / 128; end
                            3: begin er = a / 2 + c * 128; ec = a % 2; end
                            4: begin er = (a * 2) % 256; ec = a / 128; end
                            5: begin er = a / 2 + (a / 128) * 128; ec = a % 2; end
                            default: begin er = a; ec = c; end
                        endcase
                        ez = (er == 0) ? 1 : 0;
                        if (o < 4 && s == 1) ez = 0;
                        @(negedge clk);
                        chk(op_req(o), result, er);
                        chk(op_req(o), flags[4], ec);
                        // R7 subtract, half-carry and low nibble
                        chk("R7", {flags[6:5], flags[3:0]}, 0);
                        if (o < 4 && s == 1) chk("R9", flags[7], ez);
                        else if ((o == 4 || o == 5) && s == 1) chk("R10", flags[7], ez);
                        else chk("R8", flags[7], ez);
                    end
                end
            end
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule